// File: doc/BRIEF.md
# UART Channel Data and Status Register Interface

This block is the register layer of one UART channel. It sits between a simple CPU register bus and the channel's transmit and receive engines. The bus has an address, a write strobe, a read strobe and 16-bit write and read data. One data address serves both directions: a bus write to it fills the transmit buffer, and a bus read from it returns the receive buffer. A status register reports transmit-empty, receive-full, parity-error and overrun-error. A control register selects 7-bit characters, enables the interrupt request, and carries an error-clear bit. Error flags are cleared only by writing 0 to that bit, not through the status register.

The transmit side is a valid/ready stream. The buffered byte is offered while `txo_valid` is high. The engine takes it on a cycle where `txo_valid` and `txo_ready` are both high, and that handshake makes the buffer empty again. The engine may hold `txo_ready` low for as long as it likes. The byte and `txo_valid` then stay stable.

The receive side has no back-pressure. The engine raises `rxi_valid` for one cycle per delivered byte and cannot be stalled. A byte that arrives while the previous one is still unread is an overrun, and the earlier byte is kept. The bit-level shifting, baud timing and parity computation belong to the engines.

Top module: `uart_regif`

Register map (address in `bus_addr`): 0 = data, 1 = status, 2 = control, 3 = unmapped.

## Requirements
- R1: A write to address 0, when accepted, loads `bus_wdata[7:0]` into the transmit buffer, which appears on `txo_data` from the next cycle. A read of address 0 returns the receive buffer in `bus_rdata[7:0]` in the same cycle, with bits 15:8 at 0.
- R2: `txo_valid` is the inverse of the transmit-empty flag.
  - A write to address 0 while transmit-empty is 0 is ignored and leaves the buffer unchanged.
  - An accepted write clears transmit-empty at the next edge.
  - A `txo_valid`/`txo_ready` handshake sets transmit-empty at the next edge.
- R3: While control bit 8 (7-bit mode) is 1, bit 7 of the read data byte and `txo_data[7]` are 0. The other bits are unaffected.
- R4: A `rxi_valid` pulse while receive-full is 0 loads `rxi_data` and sets receive-full.
  - A read of address 0 while receive-full is 1 clears it at the next edge.
  - If a new byte arrives in that same cycle, the new byte is loaded and receive-full stays 1. This is not an overrun.
- R5: A `rxi_valid` pulse while receive-full is 1 and no data read occurs in that cycle sets the overrun flag. The receive buffer keeps the earlier byte.
- R6: A `rxi_valid` pulse with `rxi_perr` high sets the parity-error flag.
- R7: The two error flags are cleared only by a control write with bit 10 = 0.
  - A control write with bit 10 = 1 leaves them unchanged.
  - An error event in the same cycle as a clear leaves its flag set.
- R8: The status register reads with parity-error at bit 15, overrun at bit 14, receive-full at bit 12 and transmit-empty at bit 11; all other bits are 0.
  - The control register reads with bit 10 = 1, bit 9 = interrupt enable, bit 8 = 7-bit mode, and all other bits 0.
- R9: `irq` is 1 exactly when the interrupt enable bit (control bit 9) is 1 and at least one of parity-error, overrun or receive-full is 1.
- R10: After reset, transmit-empty is 1 and every other flag, control bit and buffer is 0.
- R11: `bus_rdata` is 0 while `bus_rd` is 0 and on a read of address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| txo_valid | output | 1 | Transmit buffer holds a byte for the engine |
| txo_ready | input | 1 | Transmit engine takes the byte |
| txo_data | output | 8 | Transmit byte, bit 7 masked in 7-bit mode |
| rxi_valid | input | 1 | Receive engine delivers a byte (single-cycle pulse) |
| rxi_data | input | 8 | Delivered byte |
| rxi_perr | input | 1 | Delivered byte failed its parity check |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can meet in the same cycle:
- A data-address read that drains the receive buffer and a `rxi_valid` delivery, which must load the new byte without flagging an overrun.
- A control write that clears the errors and a parity or overrun event, where the set must win.

Both pairs are provoked by directed sequences that line the events up on one edge. Random traffic with dense `rxi_valid` and read strobes also makes them collide repeatedly. A bench model that applies set-over-clear and read-then-load ordering judges each case through the status register and the data reads that follow.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_STAT = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // status bit positions
  localparam int ST_PERR = 15;
  localparam int ST_OVR  = 14;
  localparam int ST_RXF  = 12;
  localparam int ST_TXE  = 11;
  // control bit positions
  localparam int CT_CLR  = 10;
  localparam int CT_IEN  = 9;
  localparam int CT_C7   = 8;

  typedef struct packed {
    logic perr;
    logic ovr;
    logic rxf;
    logic txe;
  } chan_stat_t;
endpackage

// File: rtl/uart_ctrl_reg.sv
module uart_ctrl_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ctl,
  input  logic wbit_clr,
  input  logic wbit_ien,
  input  logic wbit_c7,
  output logic ien,
  output logic char7,
  output logic err_clr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien   <= 1'b0;
      char7 <= 1'b0;
    end else if (wr_ctl) begin
      ien   <= wbit_ien;
      char7 <= wbit_c7;
    end
  end

  assign err_clr = wr_ctl && !wbit_clr;

  // R8
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> (ien == $past(wbit_ien)) && (char7 == $past(wbit_c7)));
endmodule

// File: rtl/uart_tx_buf.sv
module uart_tx_buf #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_data,
  input  logic [CHAR_W-1:0] wbyte,
  input  logic              char7,
  input  logic              txo_ready,
  output logic              txo_valid,
  output logic [CHAR_W-1:0] txo_data,
  output logic              txe
);
  localparam logic [CHAR_W-1:0] MASK7 = {1'b0, {(CHAR_W-1){1'b1}}};

  logic [CHAR_W-1:0] buf_q;
  logic              txe_q;
  logic              accept, handoff;

  assign accept  = wr_data && txe_q;
  assign handoff = !txe_q && txo_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      txe_q <= 1'b1;
    end else begin
      if (accept) begin
        buf_q <= wbyte;
        txe_q <= 1'b0;
      end else if (handoff) begin
        txe_q <= 1'b1;
      end
    end
  end

  assign txe       = txe_q;
  assign txo_valid = !txe_q;
  assign txo_data  = char7 ? (buf_q & MASK7) : buf_q;

  // R2
  tx_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !txe_q) |=> $stable(buf_q));
  // R2
  tx_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && txe_q) |=> (!txe_q && buf_q == $past(wbyte)));
  // R2
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txo_valid && !txo_ready) |=> (txo_valid && $stable(buf_q)));
endmodule

// File: rtl/uart_rx_buf.sv
module uart_rx_buf #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxi_valid,
  input  logic [CHAR_W-1:0] rxi_data,
  input  logic              rxi_perr,
  input  logic              rd_data,
  input  logic              err_clr,
  input  logic              char7,
  output logic [CHAR_W-1:0] rd_byte,
  output logic              rxf,
  output logic              perr,
  output logic              ovr
);
  localparam logic [CHAR_W-1:0] MASK7 = {1'b0, {(CHAR_W-1){1'b1}}};

  logic [CHAR_W-1:0] buf_q;
  logic rxf_q, perr_q, ovr_q;
  logic take, overrun, load;

  assign take    = rd_data && rxf_q;
  assign overrun = rxi_valid && rxf_q && !take;
  assign load    = rxi_valid && !overrun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      rxf_q  <= 1'b0;
      perr_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (load) begin
        buf_q <= rxi_data;
        rxf_q <= 1'b1;
      end else if (take) begin
        rxf_q <= 1'b0;
      end
      if (rxi_valid && rxi_perr) perr_q <= 1'b1;
      else if (err_clr)          perr_q <= 1'b0;
      if (overrun)               ovr_q  <= 1'b1;
      else if (err_clr)          ovr_q  <= 1'b0;
    end
  end

  assign rd_byte = char7 ? (buf_q & MASK7) : buf_q;
  assign rxf     = rxf_q;
  assign perr    = perr_q;
  assign ovr     = ovr_q;

  // R5
  rx_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxi_valid && rxf_q && !rd_data) |=> (ovr_q && $stable(buf_q)));
  // R4
  rx_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && rxf_q && !rxi_valid) |=> !rxf_q);
  // R7
  err_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(perr_q) || $fell(ovr_q)) |-> $past(err_clr));
  // R6
  perr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxi_valid && rxi_perr) |=> perr_q);
endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              txo_valid,
  input  logic              txo_ready,
  output logic [CHAR_W-1:0] txo_data,
  input  logic              rxi_valid,
  input  logic [CHAR_W-1:0] rxi_data,
  input  logic              rxi_perr,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(SEL_DATA);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(SEL_STAT);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(SEL_CTRL);

  logic wr_data, rd_data, wr_ctl;
  logic ien, char7, err_clr;
  logic [CHAR_W-1:0] rd_byte;
  chan_stat_t st;

  assign wr_data = bus_wr && (bus_addr == A_DATA);
  assign rd_data = bus_rd && (bus_addr == A_DATA);
  assign wr_ctl  = bus_wr && (bus_addr == A_CTRL);

  uart_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ctl   (wr_ctl),
    .wbit_clr (bus_wdata[CT_CLR]),
    .wbit_ien (bus_wdata[CT_IEN]),
    .wbit_c7  (bus_wdata[CT_C7]),
    .ien      (ien),
    .char7    (char7),
    .err_clr  (err_clr)
  );

  uart_tx_buf #(.CHAR_W(CHAR_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_data   (wr_data),
    .wbyte     (bus_wdata[CHAR_W-1:0]),
    .char7     (char7),
    .txo_ready (txo_ready),
    .txo_valid (txo_valid),
    .txo_data  (txo_data),
    .txe       (st.txe)
  );

  uart_rx_buf #(.CHAR_W(CHAR_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .rxi_valid (rxi_valid),
    .rxi_data  (rxi_data),
    .rxi_perr  (rxi_perr),
    .rd_data   (rd_data),
    .err_clr   (err_clr),
    .char7     (char7),
    .rd_byte   (rd_byte),
    .rxf       (st.rxf),
    .perr      (st.perr),
    .ovr       (st.ovr)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_DATA: bus_rdata[CHAR_W-1:0] = rd_byte;
        A_STAT: begin
          bus_rdata[ST_PERR] = st.perr;
          bus_rdata[ST_OVR]  = st.ovr;
          bus_rdata[ST_RXF]  = st.rxf;
          bus_rdata[ST_TXE]  = st.txe;
        end
        A_CTRL: begin
          bus_rdata[CT_CLR] = 1'b1;
          bus_rdata[CT_IEN] = ien;
          bus_rdata[CT_C7]  = char7;
        end
        default: bus_rdata = '0;
      endcase
    end
  end

  assign irq = ien && (st.perr || st.ovr || st.rxf);

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ien |-> !irq);
  // R11
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == '0));
  // R2
  txo_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txo_valid && txo_ready) |=> !txo_valid);
endmodule

// File: tb/tb_uart_regif.sv
module tb_uart_regif;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        txo_valid, txo_ready = 1'b0;
  logic [7:0]  txo_data;
  logic        rxi_valid = 1'b0, rxi_perr = 1'b0;
  logic [7:0]  rxi_data = '0;
  logic        irq;

  int n_chk = 0, n_bad = 0;

  // bench model state
  logic m_txe, m_rxf, m_pe, m_ovr, m_ien, m_c7;
  logic [7:0] m_tx, m_rx;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regif dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .txo_valid(txo_valid), .txo_ready(txo_ready), .txo_data(txo_data),
    .rxi_valid(rxi_valid), .rxi_data(rxi_data), .rxi_perr(rxi_perr),
    .irq(irq)
  );

  function automatic logic [7:0] mask7(input logic [7:0] b, input logic c7);
    return c7 ? {1'b0, b[6:0]} : b;
  endfunction

  function automatic logic [15:0] exp_rdata(input logic [1:0] a, input logic rd);
    logic [15:0] r = '0;
    if (rd) begin
      case (a)
        2'd0: r[7:0] = mask7(m_rx, m_c7);
        2'd1: begin r[15] = m_pe; r[14] = m_ovr; r[12] = m_rxf; r[11] = m_txe; end
        2'd2: begin r[10] = 1'b1; r[9] = m_ien; r[8] = m_c7; end
        default: r = '0;
      endcase
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_txe = 1'b1; m_rxf = 1'b0; m_pe = 1'b0; m_ovr = 1'b0;
    m_ien = 1'b0; m_c7 = 1'b0; m_tx = '0; m_rx = '0;
  endtask

  // one bus cycle: drive at negedge, check before the edge, then advance the model
  task automatic step(input logic [1:0] a, input logic wr, input logic rd,
                      input logic [15:0] wd, input logic rv, input logic [7:0] rdat,
                      input logic rp, input logic tr);
    logic take, ovr_ev, clr, hs;
    string tg;
    @(negedge clk);
    bus_addr = a; bus_wr = wr; bus_rd = rd; bus_wdata = wd;
    rxi_valid = rv; rxi_data = rdat; rxi_perr = rp; txo_ready = tr;
    #1;
    tg = (!rd || a == 2'd3) ? "R11" : (a == 2'd0) ? "R1 read" : "R8";
    check(tg, bus_rdata, exp_rdata(a, rd));
    check("R2 txo_valid", {15'd0, txo_valid}, {15'd0, !m_txe});
    check(m_c7 ? "R3 txo_data" : "R1 txo_data", {8'd0, txo_data}, {8'd0, mask7(m_tx, m_c7)});
    check("R9 irq", {15'd0, irq}, {15'd0, m_ien & (m_pe | m_ovr | m_rxf)});
    // next state
    hs     = !m_txe && tr;
    take   = rd && a == 2'd0 && m_rxf;
    ovr_ev = rv && m_rxf && !take;
    clr    = wr && a == 2'd2 && !wd[10];
    if (wr && a == 2'd0 && m_txe) begin m_tx = wd[7:0]; m_txe = 1'b0; end
    else if (hs) m_txe = 1'b1;
    if (rv && rp) m_pe = 1'b1; else if (clr) m_pe = 1'b0;
    if (ovr_ev) m_ovr = 1'b1; else if (clr) m_ovr = 1'b0;
    if (rv && !ovr_ev) begin m_rx = rdat; m_rxf = 1'b1; end
    else if (take) m_rxf = 1'b0;
    if (wr && a == 2'd2) begin m_ien = wd[9]; m_c7 = wd[8]; end
  endtask

  task automatic idle();
    step(2'd1, 1'b0, 1'b1, 16'h0, 1'b0, 8'h0, 1'b0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'd2024);
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state via status and control reads
    idle();
    step(2'd2, 1'b0, 1'b1, 16'h0, 1'b0, 8'h0, 1'b0, 1'b0);

    // R1 / R2: load, ignored second write, handshake after stall
    step(2'd0, 1'b1, 1'b0, 16'h00A5, 1'b0, 8'h0, 1'b0, 1'b0);
    step(2'd0, 1'b1, 1'b0, 16'h003C, 1'b0, 8'h0, 1'b0, 1'b0);
    step(2'd1, 1'b0, 1'b1, 16'h0, 1'b0, 8'h0, 1'b0, 1'b0);
    step(2'd1, 1'b0, 1'b1, 16'h0, 1'b0, 8'h0, 1'b0, 1'b1);
    idle();

    // R3: 7-bit mode masks both directions, interrupt enable on
    step(2'd2, 1'b1, 1'b0, 16'h0700, 1'b0, 8'h0, 1'b0, 1'b0);
    step(2'd0, 1'b1, 1'b0, 16'h00FF, 1'b0, 8'h0, 1'b0, 1'b0);
    step(2'd1, 1'b0, 1'b1, 16'h0, 1'b1, 8'hC3, 1'b0, 1'b0);
    step(2'd0, 1'b0, 1'b1, 16'h0, 1'b0, 8'h0, 1'b0, 1'b1);
    step(2'd2, 1'b1, 1'b0, 16'h0600, 1'b0, 8'h0, 1'b0, 1'b0);

    // R4: delivery and drain in the same cycle, no overrun
    step(2'd1, 1'b0, 1'b1, 16'h0, 1'b1, 8'h11, 1'b0, 1'b0);
    step(2'd0, 1'b0, 1'b1, 16'h0, 1'b1, 8'h22, 1'b0, 1'b0);
    step(2'd0, 1'b0, 1'b1, 16'h0, 1'b0, 8'h0, 1'b0, 1'b0);
    idle();

    // R5: overrun keeps the earlier byte
    step(2'd1, 1'b0, 1'b1, 16'h0, 1'b1, 8'h33, 1'b0, 1'b0);
    step(2'd1, 1'b0, 1'b1, 16'h0, 1'b1, 8'h44, 1'b0, 1'b0);
    step(2'd0, 1'b0, 1'b1, 16'h0, 1'b0, 8'h0, 1'b0, 1'b0);

    // R6 / R7: parity set, clear with bit 10 = 1 ignored, set wins over clear
    step(2'd1, 1'b0, 1'b1, 16'h0, 1'b1, 8'h55, 1'b1, 1'b0);
    step(2'd2, 1'b1, 1'b0, 16'h0600, 1'b0, 8'h0, 1'b0, 1'b0);
    idle();
    step(2'd2, 1'b1, 1'b0, 16'h0200, 1'b1, 8'h66, 1'b1, 1'b0);
    idle();
    step(2'd2, 1'b1, 1'b0, 16'h0200, 1'b0, 8'h0, 1'b0, 1'b0);
    idle();
    step(2'd3, 1'b0, 1'b1, 16'h0, 1'b0, 8'h0, 1'b0, 1'b0);

    // random traffic with dense collisions
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] a;
      logic [15:0] wd;
      a  = 2'($urandom_range(0, 3));
      wd = 16'($urandom);
      if (a == 2'd2 && ($urandom_range(0, 3) != 0)) wd[10] = 1'b1;
      step(a, ($urandom_range(0, 3) == 0), ($urandom_range(0, 1) == 1), wd,
           ($urandom_range(0, 2) == 0), 8'($urandom), ($urandom_range(0, 4) == 0),
           ($urandom_range(0, 2) == 0));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule